// File: doc/BRIEF.md
# Serial Bit-Step Shifter

This block shifts a 32-bit integer one bit position per clock. It handles logical left, logical right and arithmetic right shifts. A pipeline controller pulses `start` with the operand, a 5-bit distance and an operation select. The unit loads a shift register and a down-counter. It then steps the register once per clock until a zero comparator on the decremented count reports that the last step has been taken. Throughout the run it raises `stall`, so the controller holds the issuing stage and lets later stages drain with bubbles. In the cycle the result is ready, `done` pulses and `stall` falls.

The controller has three named states. In `ST_IDLE` the unit waits for `start`. A zero distance finishes at once: the operand passes straight through in the same cycle and the state does not change. A distance of one goes straight to `ST_FINISH`. Any larger distance goes to `ST_SHIFT`. `ST_SHIFT` takes one step per clock and moves to `ST_FINISH` when the counter's last step is seen. `ST_FINISH` presents the result with `done` and always returns to `ST_IDLE`. The first step is taken on the same edge that loads the operand, so the total latency equals the distance.

Top module: `serial_shifter`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `stall` and `done` are 0.
- R2: `opsel` = 2'b00 selects a logical left shift. Zeros enter at bit 0.
- R3: `opsel` = 2'b01 selects a logical right shift. Zeros enter at bit 31.
- R4: `opsel` = 2'b10 or 2'b11 selects an arithmetic right shift. Each step copies bit 31 into the vacated position.
- R5: For a distance N > 0 accepted in cycle 0, `done` is high in cycle N only, for exactly one cycle.
- R6: For N > 0, `stall` is high from cycle 0 through cycle N-1 and low in cycle N. `stall` and `done` are never high together.
- R7: A distance of 0 gives `done` = 1, `result` = `operand` and `stall` = 0 in the start cycle itself.
- R8: A `start` that arrives while a shift is in progress (`ST_SHIFT`), or in the cycle `done` is high (`ST_FINISH`), is ignored. The running result and its timing do not change, and no new operation begins.
- R9: While `done` is high, `result` carries the shifted value of the accepted operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a shift when the unit is idle |
| operand | input | 32 | Value to shift |
| amount | input | 5 | Shift distance in bit positions |
| opsel | input | 2 | 00 left logical, 01 right logical, 1x right arithmetic |
| stall | output | 1 | Hold request to the pipeline controller |
| result | output | 32 | Shifted value, valid while `done` is high |
| done | output | 1 | One-cycle completion strobe |

## Verification
The start cycle is counted as cycle 0. The bench drives inputs on the falling edge and samples one time unit later. This lets the zero-distance path, which is combinational, be checked in cycle 0. `done` is due exactly N cycles after the start cycle, and `stall` must be high in every cycle before that. The bench therefore counts falling edges from the start cycle and compares the count at which `done` appears against N. It also confirms that `stall` held throughout the run and that `done` is gone one cycle later. The ignored-start cases present a second `start` mid-run and in the `done` cycle. They then check that the original result still arrives at its original cycle and that no new `stall` appears.

// File: rtl/sshift_pkg.sv
package sshift_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_FINISH = 2'd2
    } sstate_t;

    localparam logic [1:0] OPS_LEFT  = 2'b00;
    localparam logic [1:0] OPS_RIGHT = 2'b01;

endpackage

// File: rtl/sshift_count.sv
module sshift_count #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_dec;

    assign cnt_dec = cnt_q - 1'b1;
    assign last    = (cnt_dec == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec) begin
            cnt_q <= cnt_dec;
        end
    end

    // R5: each step removes exactly one from the remaining count
    a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sshift_dp.sv
module sshift_dp
    import sshift_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [DW-1:0] operand,
    input  logic [1:0]    opsel,
    output logic [DW-1:0] q
);
    logic [1:0] op_q;

    function automatic logic [DW-1:0] one_step(input logic [DW-1:0] v,
                                               input logic [1:0] op);
        logic [DW-1:0] r;
        if (op == OPS_LEFT)       r = {v[DW-2:0], 1'b0};
        else if (op == OPS_RIGHT) r = {1'b0, v[DW-1:1]};
        else                      r = {v[DW-1], v[DW-1:1]};
        return r;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            op_q <= OPS_LEFT;
        end else if (load) begin
            q    <= one_step(operand, opsel);
            op_q <= opsel;
        end else if (step) begin
            q    <= one_step(q, op_q);
        end
    end

    // R4: arithmetic steps keep the sign bit
    a_r4_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && op_q[1]) |=> (q[DW-1] == $past(q[DW-1])));

    // R2: left steps shift a zero into bit 0
    a_r2_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && op_q == OPS_LEFT) |=> (q[0] == 1'b0));

endmodule

// File: rtl/sshift_ctrl.sv
module sshift_ctrl
    import sshift_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic amt_zero,
    input  logic amt_one,
    input  logic last,
    output logic load,
    output logic step,
    output logic stall,
    output logic done,
    output logic bypass
);
    sstate_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        step    = 1'b0;
        stall   = 1'b0;
        done    = 1'b0;
        bypass  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start && amt_zero) begin
                    done   = 1'b1;
                    bypass = 1'b1;
                end else if (start) begin
                    load    = 1'b1;
                    stall   = 1'b1;
                    state_d = amt_one ? ST_FINISH : ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                step    = 1'b1;
                stall   = 1'b1;
                state_d = last ? ST_FINISH : ST_SHIFT;
            end
            ST_FINISH: begin
                done    = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R5: the finish state lasts one cycle
    a_r5_finish_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINISH) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/serial_shifter.sv
module serial_shifter #(
    parameter int DW = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [DW-1:0]         operand,
    input  logic [$clog2(DW)-1:0] amount,
    input  logic [1:0]            opsel,
    output logic                  stall,
    output logic [DW-1:0]         result,
    output logic                  done
);
    localparam int AW = $clog2(DW);

    logic          load, step, last, bypass;
    logic [AW-1:0] amt_m1;
    logic [DW-1:0] q;

    assign amt_m1 = amount - 1'b1;

    sshift_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .amt_zero (amount == '0),
        .amt_one  (amt_m1 == '0),
        .last     (last),
        .load     (load),
        .step     (step),
        .stall    (stall),
        .done     (done),
        .bypass   (bypass)
    );

    sshift_count #(.CNT_W(AW)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (amt_m1),
        .dec      (step),
        .last     (last)
    );

    sshift_dp #(.DW(DW)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .operand (operand),
        .opsel   (opsel),
        .q       (q)
    );

    assign result = bypass ? operand : q;

    // R6: stall and done never overlap
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall && done));

    // R6: a stall is followed by more stall or by completion
    a_r6_resolves: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (stall || done));

    // R7: zero distance passes the operand through at once
    a_r7_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |-> (done && !stall && result == operand));

endmodule

// File: tb/serial_shifter_test.sv
module serial_shifter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] operand = '0;
    logic [4:0]  amount = '0;
    logic [1:0]  opsel = '0;
    logic        stall, done;
    logic [31:0] result;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    serial_shifter uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .operand (operand),
        .amount  (amount),
        .opsel   (opsel),
        .stall   (stall),
        .result  (result),
        .done    (done)
    );

    // {operand, amount, opsel, expected}
    localparam logic [70:0] VEC [10] = '{
        {32'h0000_0001, 5'd4,  2'b00, 32'h0000_0010},
        {32'h8000_0000, 5'd31, 2'b01, 32'h0000_0001},
        {32'h8000_0000, 5'd31, 2'b10, 32'hFFFF_FFFF},
        {32'hF000_000F, 5'd4,  2'b10, 32'hFF00_0000},
        {32'h1234_5678, 5'd8,  2'b00, 32'h3456_7800},
        {32'h1234_5678, 5'd1,  2'b01, 32'h091A_2B3C},
        {32'h7FFF_FFFF, 5'd3,  2'b10, 32'h0FFF_FFFF},
        {32'hDEAD_BEEF, 5'd0,  2'b00, 32'hDEAD_BEEF},
        {32'hA5A5_A5A5, 5'd16, 2'b11, 32'hFFFF_A5A5},
        {32'h0000_0001, 5'd31, 2'b00, 32'h8000_0000}
    };

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string op_req(input logic [1:0] op);
        if (op == 2'b00) return "R2 left";
        if (op == 2'b01) return "R3 logical right";
        return "R4 arithmetic right";
    endfunction

    task automatic run_one(input logic [31:0] opd, input logic [4:0] amt,
                           input logic [1:0] op, input logic [31:0] exp);
        int  cyc;
        bit  held;
        @(negedge clk);
        start = 1'b1; operand = opd; amount = amt; opsel = op;
        #1;
        if (amt == 5'd0) begin
            chk(done === 1'b1, "R7 done in start cycle", {31'd0, done}, 32'd1);
            chk(stall === 1'b0, "R7 no stall", {31'd0, stall}, 32'd0);
            chk(result === exp, "R7 operand passthrough", result, exp);
            @(negedge clk); start = 1'b0; #1;
            chk(done === 1'b0, "R5 single pulse", {31'd0, done}, 32'd0);
            return;
        end
        chk(stall === 1'b1 && done === 1'b0, "R6 stall in start cycle",
            {30'd0, stall, done}, 32'd2);
        held = 1'b1;
        cyc  = 0;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk); start = 1'b0; #1;
            cyc = k;
            if (done === 1'b1) break;
            if (stall !== 1'b1) held = 1'b0;
        end
        chk(cyc == int'(amt), "R5 latency", cyc, int'(amt));
        chk(held, "R6 stall held during run", {31'd0, held}, 32'd1);
        chk(stall === 1'b0, "R6 stall low at done", {31'd0, stall}, 32'd0);
        chk(result === exp, op_req(op), result, exp);
        @(negedge clk); #1;
        chk(done === 1'b0, "R5 single pulse", {31'd0, done}, 32'd0);
    endtask

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cyc;
        // R1: reset state
        #2;
        chk(stall === 1'b0 && done === 1'b0, "R1 in reset", {30'd0, stall, done}, 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(stall === 1'b0 && done === 1'b0, "R1 after reset", {30'd0, stall, done}, 32'd0);

        // Vector table: R2 R3 R4 R5 R6 R7 R9
        for (int i = 0; i < 10; i++)
            run_one(VEC[i][70:39], VEC[i][38:34], VEC[i][33:32], VEC[i][31:0]);

        // R8: start mid-run is ignored
        @(negedge clk);
        start = 1'b1; operand = 32'h0000_0001; amount = 5'd8; opsel = 2'b00;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        start = 1'b1; operand = 32'hFFFF_FFFF; amount = 5'd0; opsel = 2'b10;
        #1;
        chk(done === 1'b0 && stall === 1'b1, "R8 mid-run start ignored",
            {30'd0, stall, done}, 32'd2);
        cyc = 2;
        for (int k = 3; k <= 40; k++) begin
            @(negedge clk); start = 1'b0; #1;
            cyc = k;
            if (done === 1'b1) break;
        end
        chk(cyc == 8, "R8 timing unchanged", cyc, 8);
        chk(result === 32'h0000_0100, "R9 R8 result unchanged", result, 32'h0000_0100);

        // R8: start in the done cycle is ignored
        start = 1'b1; operand = 32'h5; amount = 5'd3; opsel = 2'b00;
        #1;
        chk(stall === 1'b0, "R8 start at done ignored", {31'd0, stall}, 32'd0);
        chk(result === 32'h0000_0100, "R9 result at done", result, 32'h0000_0100);
        @(negedge clk); start = 1'b0; #1;
        chk(stall === 1'b0 && done === 1'b0, "R8 no new run", {30'd0, stall, done}, 32'd0);

        // R1: reset during a run
        @(negedge clk);
        start = 1'b1; operand = 32'h1; amount = 5'd20; opsel = 2'b00;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0; #1;
        chk(stall === 1'b0 && done === 1'b0, "R1 reset mid-run", {30'd0, stall, done}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1;
        chk(stall === 1'b0 && done === 1'b0, "R1 idle after reset", {30'd0, stall, done}, 32'd0);

        run_one(32'h0000_00F0, 5'd2, 2'b01, 32'h0000_003C);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule